// File: doc/BRIEF.md
# Interrupt Flag Controller for a Small Microcontroller Core

This block collects three interrupt causes for an 8-bit microcontroller core and turns them into a single request to branch to the interrupt vector. The causes are an edge on an asynchronous external pin, a one-cycle overflow pulse from an 8-bit timer, and any difference between the upper four bits of an input port and a snapshot of those bits. Each cause has a sticky flag and an enable bit. Both live in one 8-bit control register that software reads and writes, together with a global enable.

The external pin passes through a two-stage synchronizer. A polarity input then chooses whether a rising or a falling edge counts. Only hardware events set the flags. Only a software write clears them. When a hardware set and a software clear meet in the same cycle, the set wins.

There are two outputs. The vector request needs the global enable. The wake-up output is used while the core sleeps and ignores the global enable, so a sleeping core can wake and carry on without taking the vector. When the core acknowledges the vector branch, the global enable clears.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset, the control register reads 0x00, `irq_req` is 0 and `wake_req` is 0.
- R2: When `edge_rise_sel` is 1, a rising edge on `ext_pin` sets control bit 1 within four clock cycles, and a falling edge leaves it unchanged.
- R3: When `edge_rise_sel` is 0, a falling edge on `ext_pin` sets control bit 1, and a rising edge leaves it unchanged.
- R4: A one-cycle pulse on `tmr_ovf` sets control bit 2 on the next clock edge.
- R5: Control bit 0 is set in every cycle in which `port_hi` differs from the snapshot. A `port_rd` pulse loads the snapshot from `port_hi`, and the snapshot resets to 0. A clear of bit 0 sticks only once the port matches the snapshot.
- R6: Flags at bits 2:0 are never cleared by hardware. A write clears or sets them, and a hardware set in the same cycle as a write of 0 leaves the flag at 1.
- R7: `irq_req` = bit 7 AND ((bit0 AND bit3) OR (bit1 AND bit4) OR (bit2 AND bit5)). Bits 3, 4 and 5 enable the port, pin and timer sources respectively.
- R8: `irq_ack` clears bit 7 on the next clock edge, leaves the other bits unchanged, and overrides a write of 1 to bit 7 in the same cycle.
- R9: `wake_req` = `core_sleep` AND ((bit0 AND bit3) OR (bit1 AND bit4) OR (bit2 AND bit5)), independent of bit 7.
- R10: Bit 6 of the control register is not implemented and always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin | input | 1 | External interrupt pin, asynchronous |
| edge_rise_sel | input | 1 | 1 selects rising edges on `ext_pin`, 0 selects falling edges |
| tmr_ovf | input | 1 | One-cycle pulse when the timer wraps from 0xFF to 0x00 |
| port_hi | input | 4 | Upper four input-port bits, synchronous to `clk` |
| port_rd | input | 1 | Software read of the port; reloads the snapshot |
| ctl_wr_en | input | 1 | Write strobe for the control register |
| ctl_wr_data | input | 8 | Write data for the control register |
| ctl_rd_data | output | 8 | Current control register contents |
| core_sleep | input | 1 | Core is in sleep mode |
| irq_ack | input | 1 | Core has taken the vector branch |
| irq_req | output | 1 | Request to branch to the interrupt vector |
| wake_req | output | 1 | Wake-up request while sleeping |

## Verification
The assertions take for granted that `tmr_ovf`, `port_hi`, `port_rd` and the write port are synchronous to `clk`. They also take for granted that `irq_ack` only arrives as a single-cycle pulse, and that only a write may lower a flag. The stimulus changes every input at the falling clock edge. It never changes `ext_pin` again until the synchronizer and the flag have settled. It keeps the pin and the port steady while the vector table writes flags directly, so no hardware set can disturb the table's expected values.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;
  localparam int CTL_W   = 8;
  localparam int NSRC    = 3;
  // flag bit positions; each enable sits NSRC bits above its flag
  localparam int B_PFLAG = 0;
  localparam int B_XFLAG = 1;
  localparam int B_TFLAG = 2;
  localparam int B_GIE   = 7;
  localparam int EN_OFS  = NSRC;
  localparam logic [CTL_W-1:0] CTL_RST  = 8'h00;
  localparam logic [CTL_W-1:0] CTL_MASK = 8'hBF;
  typedef logic [NSRC-1:0] src_vec_t;
endpackage

// File: rtl/irq_flag_rst_sync.sv
module irq_flag_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/irq_flag_edge_det.sv
module irq_flag_edge_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic rise_sel,
  output logic edge_hit
);
  localparam int FILL_W = SYNC_STAGES + 1;

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   last_q, last_d;
  logic [FILL_W-1:0]      fill_q, fill_d;
  logic                   level, armed;

  // the fill chain hides the first samples after reset so that a pin already
  // high or low at reset release is not taken for an edge
  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], pin};
    last_d = sync_q[SYNC_STAGES-1];
    fill_d = {fill_q[FILL_W-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
      fill_q <= '0;
    end else begin
      sync_q <= sync_d;
      last_q <= last_d;
      fill_q <= fill_d;
    end
  end

  assign level    = sync_q[SYNC_STAGES-1];
  assign armed    = fill_q[FILL_W-1];
  assign edge_hit = armed & (rise_sel ? (level & ~last_q) : (~level & last_q));
endmodule

// File: rtl/irq_flag_port_watch.sv
module irq_flag_port_watch #(
  parameter int PORT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PORT_W-1:0] port_in,
  input  logic              snap_en,
  output logic              changed
);
  logic [PORT_W-1:0] snap_q, snap_d;

  always_comb begin
    snap_d = snap_q;
    if (snap_en) snap_d = port_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) snap_q <= '0;
    else        snap_q <= snap_d;
  end

  assign changed = |(port_in ^ snap_q);
endmodule

// File: rtl/irq_flag_reg.sv
module irq_flag_reg
  import irq_flag_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  src_vec_t         set_vec,
  input  logic             wr_en,
  input  logic [CTL_W-1:0] wr_data,
  input  logic             ack,
  output logic [CTL_W-1:0] ctl_q
);
  logic [CTL_W-1:0] ctl_d;

  // order of precedence: software write, then hardware flag set, then ack
  always_comb begin
    ctl_d = ctl_q;
    if (wr_en) ctl_d = wr_data & CTL_MASK;
    ctl_d[NSRC-1:0] = ctl_d[NSRC-1:0] | set_vec;
    if (ack) ctl_d[B_GIE] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= CTL_RST;
    else        ctl_q <= ctl_d;
  end
endmodule

// File: rtl/irq_flag_req.sv
module irq_flag_req
  import irq_flag_pkg::*;
(
  input  logic [CTL_W-1:0] ctl,
  input  logic             sleep,
  output logic             irq,
  output logic             wake
);
  src_vec_t pend;

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    assign pend[s] = ctl[s] & ctl[s + EN_OFS];
  end

  assign irq  = ctl[B_GIE] & (|pend);
  assign wake = sleep & (|pend);
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
  import irq_flag_pkg::*;
#(
  parameter int PORT_W      = 4,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_pin,
  input  logic              edge_rise_sel,
  input  logic              tmr_ovf,
  input  logic [PORT_W-1:0] port_hi,
  input  logic              port_rd,
  input  logic              ctl_wr_en,
  input  logic [CTL_W-1:0]  ctl_wr_data,
  output logic [CTL_W-1:0]  ctl_rd_data,
  input  logic              core_sleep,
  input  logic              irq_ack,
  output logic              irq_req,
  output logic              wake_req
);
  logic     rst_sync_n;
  logic     pin_hit;
  logic     port_diff;
  src_vec_t set_vec;
  logic [CTL_W-1:0] ctl_q;

  irq_flag_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  irq_flag_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .pin      (ext_pin),
    .rise_sel (edge_rise_sel),
    .edge_hit (pin_hit)
  );

  irq_flag_port_watch #(.PORT_W(PORT_W)) u_port (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .port_in (port_hi),
    .snap_en (port_rd),
    .changed (port_diff)
  );

  always_comb begin
    set_vec          = '0;
    set_vec[B_PFLAG] = port_diff;
    set_vec[B_XFLAG] = pin_hit;
    set_vec[B_TFLAG] = tmr_ovf;
  end

  irq_flag_reg u_reg (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .set_vec (set_vec),
    .wr_en   (ctl_wr_en),
    .wr_data (ctl_wr_data),
    .ack     (irq_ack),
    .ctl_q   (ctl_q)
  );

  irq_flag_req u_req (
    .ctl   (ctl_q),
    .sleep (core_sleep),
    .irq   (irq_req),
    .wake  (wake_req)
  );

  assign ctl_rd_data = ctl_q;
endmodule

// File: rtl/irq_flag_ctrl_chk.sv
module irq_flag_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] ctl,
  input logic       ctl_wr_en,
  input logic       tmr_ovf,
  input logic       irq_ack,
  input logic       core_sleep,
  input logic       irq_req,
  input logic       wake_req
);
  // R6
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_wr_en |=> ((ctl[2:0] & $past(ctl[2:0])) == $past(ctl[2:0])));
  // R4
  tmr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_ovf |=> ctl[2]);
  // R7
  gie_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (ctl[7] && (|(ctl[2:0] & ctl[5:3]))));
  // R8
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> !ctl[7]);
  // R9
  wake_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !core_sleep |-> !wake_req);
  // R9
  wake_any_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && core_sleep) |-> wake_req);
  // R10
  spare_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl[6]);
endmodule

bind irq_flag_ctrl irq_flag_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .ctl        (ctl_rd_data),
  .ctl_wr_en  (ctl_wr_en),
  .tmr_ovf    (tmr_ovf),
  .irq_ack    (irq_ack),
  .core_sleep (core_sleep),
  .irq_req    (irq_req),
  .wake_req   (wake_req)
);

// File: tb/irq_flag_ctrl_bench.sv
`timescale 1ns/1ps
module irq_flag_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ext_pin, edge_rise_sel, tmr_ovf, port_rd;
  logic [3:0] port_hi;
  logic       ctl_wr_en;
  logic [7:0] ctl_wr_data;
  logic [7:0] ctl_rd_data;
  logic       core_sleep, irq_ack, irq_req, wake_req;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  irq_flag_ctrl u_irq_flag_ctrl (
    .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .edge_rise_sel(edge_rise_sel),
    .tmr_ovf(tmr_ovf), .port_hi(port_hi), .port_rd(port_rd),
    .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data), .ctl_rd_data(ctl_rd_data),
    .core_sleep(core_sleep), .irq_ack(irq_ack), .irq_req(irq_req), .wake_req(wake_req)
  );

  // {write value, sleep, expected read, expected irq, expected wake}
  localparam logic [18:0] VEC [11] = '{
    {8'h00, 1'b0, 8'h00, 1'b0, 1'b0},
    {8'h81, 1'b0, 8'h81, 1'b0, 1'b0},
    {8'h89, 1'b0, 8'h89, 1'b1, 1'b0},
    {8'h09, 1'b1, 8'h09, 1'b0, 1'b1},
    {8'h12, 1'b1, 8'h12, 1'b0, 1'b1},
    {8'h92, 1'b1, 8'h92, 1'b1, 1'b1},
    {8'hA4, 1'b0, 8'hA4, 1'b1, 1'b0},
    {8'h24, 1'b1, 8'h24, 1'b0, 1'b1},
    {8'hB8, 1'b1, 8'hB8, 1'b0, 1'b0},
    {8'hC0, 1'b0, 8'h80, 1'b0, 1'b0},
    {8'hFF, 1'b1, 8'hBF, 1'b1, 1'b1}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk);
    ctl_wr_en = 1'b1; ctl_wr_data = v;
    @(negedge clk);
    ctl_wr_en = 1'b0;
  endtask

  task automatic wait_n(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 20000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    rst_n = 0; ext_pin = 0; edge_rise_sel = 1; tmr_ovf = 0; port_hi = 4'h0;
    port_rd = 0; ctl_wr_en = 0; ctl_wr_data = 8'h00; core_sleep = 0; irq_ack = 0;
    wait_n(3);
    chk("R1 reset ctl", ctl_rd_data, 8'h00);
    chk("R1 reset irq", {7'd0, irq_req}, 8'h00);
    chk("R1 reset wake", {7'd0, wake_req}, 8'h00);
    rst_n = 1;
    wait_n(8);

    // table walk: R7 R9 R10
    for (int i = 0; i < 11; i++) begin
      @(negedge clk);
      core_sleep = VEC[i][10];
      ctl_wr_en = 1'b1; ctl_wr_data = VEC[i][18:11];
      @(negedge clk);
      ctl_wr_en = 1'b0;
      chk("R10 table readback", ctl_rd_data, VEC[i][9:2]);
      chk("R7 table irq", {7'd0, irq_req}, {7'd0, VEC[i][1]});
      chk("R9 table wake", {7'd0, wake_req}, {7'd0, VEC[i][0]});
    end
    core_sleep = 0;
    wr(8'h00);

    // R2 rising polarity
    ext_pin = 1; wait_n(4);
    chk("R2 rise sets flag", ctl_rd_data, 8'h02);
    wr(8'h00);
    chk("R6 write clears flag", ctl_rd_data, 8'h00);
    ext_pin = 0; wait_n(4);
    chk("R2 fall ignored", ctl_rd_data, 8'h00);

    // R3 falling polarity
    edge_rise_sel = 0; wait_n(2);
    ext_pin = 1; wait_n(4);
    chk("R3 rise ignored", ctl_rd_data, 8'h00);
    ext_pin = 0; wait_n(4);
    chk("R3 fall sets flag", ctl_rd_data, 8'h02);
    edge_rise_sel = 1;
    wr(8'h00);

    // R4 timer pulse
    @(negedge clk); tmr_ovf = 1;
    @(negedge clk); tmr_ovf = 0;
    chk("R4 timer sets flag", ctl_rd_data, 8'h04);
    wr(8'h00);
    chk("R6 timer flag cleared", ctl_rd_data, 8'h00);
    // R6 set beats clear
    @(negedge clk); tmr_ovf = 1; ctl_wr_en = 1; ctl_wr_data = 8'h00;
    @(negedge clk); tmr_ovf = 0; ctl_wr_en = 0;
    chk("R6 set wins over clear", ctl_rd_data, 8'h04);
    wr(8'h00);

    // R5 port change
    @(negedge clk); port_hi = 4'h5;
    @(negedge clk);
    chk("R5 port change sets flag", ctl_rd_data, 8'h01);
    wr(8'h00);
    chk("R5 clear fails while mismatch", ctl_rd_data, 8'h01);
    @(negedge clk); port_rd = 1;
    @(negedge clk); port_rd = 0;
    wr(8'h00);
    chk("R5 clear after snapshot", ctl_rd_data, 8'h00);
    wait_n(2);
    chk("R5 matching port stays clear", ctl_rd_data, 8'h00);

    // R8 acknowledge
    wr(8'h92);
    chk("R7 irq raised", {7'd0, irq_req}, 8'h01);
    @(negedge clk); irq_ack = 1;
    @(negedge clk); irq_ack = 0;
    chk("R8 ack clears gie only", ctl_rd_data, 8'h12);
    chk("R8 irq dropped", {7'd0, irq_req}, 8'h00);
    @(negedge clk); irq_ack = 1; ctl_wr_en = 1; ctl_wr_data = 8'h92;
    @(negedge clk); irq_ack = 0; ctl_wr_en = 0;
    chk("R8 ack beats write", ctl_rd_data, 8'h12);
    core_sleep = 1; #1;
    chk("R9 wake without gie", {7'd0, wake_req}, 8'h01);
    core_sleep = 0;

    // R1 reset in mid-run
    @(negedge clk); rst_n = 0; #1;
    chk("R1 mid-run reset ctl", ctl_rd_data, 8'h00);
    port_hi = 4'h0;
    wait_n(2); rst_n = 1; wait_n(8);
    ext_pin = 1; wait_n(4);
    chk("R2 rise after reset", ctl_rd_data, 8'h02);

    summary();
  end
endmodule